// File: doc/BRIEF.md
# Indexed Byte Dot-Slice Multiply-Accumulate Row

This block updates one accumulator row of 32-bit lanes across a vector of fixed, parameterised width (`VLEN`, a multiple of 128 bits). For each 32-bit lane it picks one signed byte from the first source and one unsigned byte from the second source. It multiplies the two, widens the product to 32 bits and adds it to that lane of the incoming accumulator row. The sum wraps modulo 2^32. Every lane is updated on every operation; there is no per-lane mask.

The first-source byte for lane `e` depends on a 2-bit slice number `s`: it is byte `4*e + s` of the first source. The second-source byte is selected by a 4-bit index. The index picks one byte inside each 128-bit segment, and that byte is shared by the four lanes of the segment. A sequencer outside the block walks the slice number across four successive rows. Register storage and decode also live outside.

Operands and the accumulator row enter on a valid/ready handshake. The updated row leaves on a second valid/ready handshake, one cycle after acceptance. A single output register provides the only storage.

Back-pressure rules:
- The input is accepted only while `in_ready` is high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the presented row and `out_valid` hold still.

Top module: `idx_dot_mac`

## Requirements
- R1: The first-source byte for lane `e` is byte `4*e + slice_sel` (bits `[8*(4*e+slice_sel) +: 8]`) of `src_a`, read as two's-complement signed.
- R2: The second-source byte for lane `e` is byte `16*(e/4) + elem_idx` of `src_b`. It is the same byte offset in every 128-bit segment and is shared by the four lanes of that segment.
- R3: The second-source byte is read as unsigned (0 to 255). The lane gains the signed product, sign-extended to 32 bits.
- R4: Lane `e` of `acc_out` is `acc_in[32*e +: 32]` plus the product, modulo 2^32. Carries never cross lanes.
- R5: All `VLEN/32` lanes are updated by every accepted operation.
- R6: A row accepted at a clock edge (`in_valid` and `in_ready` high) is presented with `out_valid` high from the following edge, independent of operand values.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `acc_out` stays stable and `in_ready` is low.
- R8: During and right after reset, `out_valid` is low and `in_ready` is high.
- R9: Every index value 0 to 15 selects its own byte within each segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands and accumulator row offered |
| in_ready | output | 1 | Block can take an operation this cycle |
| src_a | input | VLEN | First source vector (signed bytes) |
| src_b | input | VLEN | Second source vector (unsigned bytes) |
| elem_idx | input | 4 | Byte index within each 128-bit segment |
| slice_sel | input | 2 | Byte slice within each 32-bit lane of `src_a` |
| acc_in | input | VLEN | Current accumulator row |
| out_valid | output | 1 | Updated row presented |
| out_ready | input | 1 | Consumer takes the row this cycle |
| acc_out | output | VLEN | Updated accumulator row |

## Verification
The properties assume that the source vectors, index, slice number and accumulator row are held steady while `in_valid` is high. They also assume that `out_ready` is a clean level sampled at each edge. The data properties model only the first and the last lane; the bench covers every lane through its scoreboard.

The stimulus changes inputs only at the falling clock edge and keeps every offer stable until it is accepted. It throttles `out_ready` in a fixed pattern so that stalls happen both while a new offer is pending and while none is.

// File: rtl/idx_dot_pkg.sv
package idx_dot_pkg;
  localparam int BYTE_W   = 8;
  localparam int LANE_W   = 32;
  localparam int SEG_W    = 128;
  localparam int SEG_BYTES = SEG_W / BYTE_W;
  localparam int LANES_PER_SEG = SEG_W / LANE_W;
  localparam int PROD_W   = 2 * BYTE_W + 1;
  localparam int IDX_W    = $clog2(SEG_BYTES);
  localparam int SLICE_W  = $clog2(LANE_W / BYTE_W);

  typedef logic [BYTE_W-1:0]  byte_t;
  typedef logic [LANE_W-1:0]  lane_t;
  typedef logic [IDX_W-1:0]   idx_t;
  typedef logic [SLICE_W-1:0] slice_t;

  // widen a signed product of PROD_W bits to a lane
  function automatic lane_t widen_prod(input logic [PROD_W-1:0] p);
    return {{(LANE_W-PROD_W){p[PROD_W-1]}}, p};
  endfunction
endpackage

// File: rtl/idx_dot_bsel.sv
// Picks one byte of a 128-bit segment by index; the result is shared by
// every lane of that segment.
module idx_dot_bsel
  import idx_dot_pkg::*;
(
  input  logic [SEG_W-1:0] seg_in,
  input  idx_t             idx,
  output byte_t            pick
);
  byte_t bytes [SEG_BYTES];

  for (genvar k = 0; k < SEG_BYTES; k++) begin : g_split
    assign bytes[k] = seg_in[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    pick = '0;
    for (int k = 0; k < SEG_BYTES; k++) begin
      if (idx == idx_t'(k)) pick = bytes[k];
    end
  end
endmodule

// File: rtl/idx_dot_lane.sv
// One 32-bit lane: signed slice byte times unsigned broadcast byte, added
// to the accumulator lane with wrap-around.
module idx_dot_lane
  import idx_dot_pkg::*;
(
  input  lane_t  a_word,
  input  slice_t slice,
  input  byte_t  b_byte,
  input  lane_t  acc,
  output lane_t  sum
);
  byte_t                    a_byte;
  logic signed [PROD_W-1:0] a_ext;
  logic signed [PROD_W-1:0] b_ext;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    a_byte = '0;
    for (int s = 0; s < LANE_W / BYTE_W; s++) begin
      if (slice == slice_t'(s)) a_byte = a_word[s*BYTE_W +: BYTE_W];
    end
  end

  // both factors fit in PROD_W signed bits and so does the product
  assign a_ext = {{(PROD_W-BYTE_W){a_byte[BYTE_W-1]}}, a_byte};
  assign b_ext = {{(PROD_W-BYTE_W){1'b0}}, b_byte};
  assign prod  = a_ext * b_ext;
  assign sum   = acc + widen_prod(prod);
endmodule

// File: rtl/idx_dot_oreg.sv
// Single-entry output register with valid/ready on both sides.
module idx_dot_oreg #(
  parameter int W = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  assign up_ready = !dn_valid || dn_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dn_valid <= 1'b0;
    else if (up_ready) dn_valid <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) dn_data <= up_data;
  end
endmodule

// File: rtl/idx_dot_mac.sv
module idx_dot_mac
  import idx_dot_pkg::*;
#(
  parameter int VLEN = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  input  logic [3:0]      elem_idx,
  input  logic [1:0]      slice_sel,
  input  logic [VLEN-1:0] acc_in,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] acc_out
);
  localparam int NSEG  = VLEN / SEG_W;
  localparam int NLANE = VLEN / LANE_W;

  if (VLEN % SEG_W != 0 || VLEN < SEG_W) begin : g_bad_len
    $error("VLEN must be a positive multiple of 128");
  end

  byte_t           seg_pick [NSEG];
  logic [VLEN-1:0] row_next;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    idx_dot_bsel u_bsel (
      .seg_in (src_b[g*SEG_W +: SEG_W]),
      .idx    (elem_idx),
      .pick   (seg_pick[g])
    );
  end

  for (genvar e = 0; e < NLANE; e++) begin : g_lane
    idx_dot_lane u_lane (
      .a_word (src_a[e*LANE_W +: LANE_W]),
      .slice  (slice_sel),
      .b_byte (seg_pick[e / LANES_PER_SEG]),
      .acc    (acc_in[e*LANE_W +: LANE_W]),
      .sum    (row_next[e*LANE_W +: LANE_W])
    );
  end

  idx_dot_oreg #(.W(VLEN)) u_oreg (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (row_next),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (acc_out)
  );
endmodule

// File: rtl/idx_dot_mac_chk.sv
module idx_dot_mac_chk #(
  parameter int VLEN = 256
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [VLEN-1:0] src_a,
  input logic [VLEN-1:0] src_b,
  input logic [3:0]      elem_idx,
  input logic [1:0]      slice_sel,
  input logic [VLEN-1:0] acc_in,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] acc_out
);
  localparam int NLANE = VLEN / 32;
  localparam int LAST  = NLANE - 1;
  localparam int LSEG  = LAST / 4;

  logic        take;
  logic [7:0]  a0, b0, an, bn;
  logic [31:0] exp_first, exp_last;

  assign take = in_valid && in_ready;
  assign a0 = src_a[8*slice_sel +: 8];
  assign b0 = src_b[8*elem_idx +: 8];
  assign an = src_a[8*(4*LAST + slice_sel) +: 8];
  assign bn = src_b[8*(16*LSEG + elem_idx) +: 8];
  assign exp_first = acc_in[31:0] + {{24{a0[7]}}, a0} * {24'b0, b0};
  assign exp_last  = acc_in[32*LAST +: 32] + {{24{an[7]}}, an} * {24'b0, bn};

  assert_first_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> acc_out[31:0] == $past(exp_first));
  // R2: last lane uses the index inside the last segment
  assert_last_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> acc_out[32*LAST +: 32] == $past(exp_last));
  assert_fixed_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);
  assert_hold_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(acc_out));
  assert_stall_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind idx_dot_mac idx_dot_mac_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .src_a(src_a), .src_b(src_b), .elem_idx(elem_idx), .slice_sel(slice_sel),
  .acc_in(acc_in), .out_valid(out_valid), .out_ready(out_ready),
  .acc_out(acc_out)
);

// File: tb/tb_idx_dot_mac.sv
module tb_idx_dot_mac;
  localparam int VLEN = 256;
  localparam int NL = VLEN / 32;
  localparam int NB = VLEN / 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [VLEN-1:0] src_a = '0, src_b = '0, acc_in = '0, acc_out;
  logic [3:0] elem_idx = '0;
  logic [1:0] slice_sel = '0;

  idx_dot_mac #(.VLEN(VLEN)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [VLEN-1:0] row; string tag; int cyc; } item_t;
  item_t sb[$];
  int checks = 0, errors = 0, cyc = 0, ready_mode = 0, rcnt = 0;
  bit seen = 0, stalled = 0, done = 0;
  logic [VLEN-1:0] held;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    rcnt = rcnt + 1;
    out_ready = (ready_mode == 0) ? 1'b1 : ((rcnt % 3) == 0);
  end

  task automatic chk(input bit ok, input string req, input logic [VLEN-1:0] act,
                     input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VLEN-1:0] model(input logic [VLEN-1:0] a, b, acc,
                                            input int idx, input int sl);
    logic [VLEN-1:0] r;
    for (int e = 0; e < NL; e++) begin
      int sa = int'($signed(a[(4*e+sl)*8 +: 8]));
      int ub = int'(b[(16*(e/4)+idx)*8 +: 8]);
      r[e*32 +: 32] = acc[e*32 +: 32] + 32'(sa * ub);
    end
    return r;
  endfunction

  task automatic send(input logic [VLEN-1:0] a, b, acc, input int idx, input int sl,
                      input string tag);
    item_t it;
    @(negedge clk);
    src_a = a; src_b = b; acc_in = acc; elem_idx = 4'(idx); slice_sel = 2'(sl);
    in_valid = 1;
    forever begin
      #2;
      if (in_ready) break;
      @(negedge clk);
    end
    it.row = model(a, b, acc, idx, sl); it.tag = tag; it.cyc = cyc;
    sb.push_back(it);
    @(posedge clk); #1;
    in_valid = 0;
  endtask

  // monitor: compares presented rows against the scoreboard
  initial forever begin
    @(negedge clk); #2;
    if (rst_n && out_valid) begin
      if (sb.size() == 0) chk(0, "R6 unexpected row", acc_out, '0);
      else begin
        if (!seen) begin
          chk(cyc == sb[0].cyc + 1, "R6 latency", VLEN'(cyc), VLEN'(sb[0].cyc + 1));
          seen = 1;
        end
        if (stalled) chk(acc_out == held, "R7 held row", acc_out, held);
        if (out_ready) begin
          chk(acc_out == sb[0].row, sb[0].tag, acc_out, sb[0].row);
          void'(sb.pop_front());
          seen = 0; stalled = 0;
        end else begin
          chk(!in_ready, "R7 in_ready low on stall", VLEN'(in_ready), '0);
          held = acc_out; stalled = 1;
        end
      end
    end else if (rst_n && stalled) begin
      chk(0, "R7 valid dropped", '0, VLEN'(1));
      stalled = 0;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] a, b, acc;
    repeat (2) @(negedge clk);
    chk(!out_valid && in_ready, "R8 in reset", {out_valid, in_ready}, VLEN'(1));
    rst_n = 1;
    @(negedge clk); #2;
    chk(!out_valid && in_ready, "R8 after reset", {out_valid, in_ready}, VLEN'(1));

    // R3: most negative signed times largest unsigned, and the positive extreme
    send({NB{8'h80}}, {NB{8'hFF}}, '0, 5, 2, "R3 neg*255");
    send({NB{8'h7F}}, {NB{8'hFF}}, '0, 0, 0, "R3 pos*255");
    send({NB{8'hFF}}, {NB{8'h01}}, {NL{32'd10}}, 9, 1, "R3 minus one");
    // R4: wrap at 2^32 and negative product crossing zero
    send({NB{8'h7F}}, {NB{8'hFF}}, {NL{32'hFFFF_FFF0}}, 3, 3, "R4 wrap up");
    send({NB{8'h80}}, {NB{8'hFF}}, {NL{32'h0000_0010}}, 3, 3, "R4 wrap down");
    // R1: slice picks byte 4e+s; each byte of a is distinct
    for (int k = 0; k < NB; k++) a[k*8 +: 8] = 8'(k * 7 + 3);
    for (int s = 0; s < 4; s++) send(a, {NB{8'h02}}, '0, 0, s, "R1 slice");
    // R2, R9: every index, each segment with its own byte values
    for (int k = 0; k < NB; k++) b[k*8 +: 8] = 8'(k * 37 + 11);
    for (int i = 0; i < 16; i++) send({NB{8'h01}}, b, {NL{32'd1000}}, i, 0, "R9 R2 index");
    // R5: lane-distinct accumulators, all lanes must move
    for (int e = 0; e < NL; e++) acc[e*32 +: 32] = 32'(e * 32'h0101_0101);
    send(a, b, acc, 7, 1, "R5 all lanes");
    // random operations, back-to-back then with back-pressure (R7)
    for (int n = 0; n < 20; n++) begin
      for (int w = 0; w < VLEN/32; w++) begin
        a[w*32 +: 32] = $urandom; b[w*32 +: 32] = $urandom; acc[w*32 +: 32] = $urandom;
      end
      if (n == 8) ready_mode = 1;
      send(a, b, acc, $urandom % 16, $urandom % 4, "R4 R5 random");
    end
    ready_mode = 0;
    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R6 drained", VLEN'(sb.size()), '0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule